// File: doc/BRIEF.md
# Audio Playback Sample Queue with Transfer Request

This block is the transmit half of an audio DAC front end. Software or a DMA engine writes PCM sample words over a simple register bus into a data port. The words wait in a 64-entry queue. Each pulse of a sample-rate strobe takes one output frame from the queue. In stereo mode a frame is two words, left then right. In mono mode it is one word, and that word drives both channels.

A transfer request line asks the DMA engine for more data. It rises when the queue has plenty of free slots and falls when it is nearly full. The rise and fall use two separate programmable thresholds, so the line does not toggle on every word. A control word sets the sample width, how 16-bit samples are widened to 24 bits, and what to play when the queue runs dry. It also holds a rate code that is passed on to the sample-clock generator. A status word and a frame counter can be read back.

Top module: `atx_tx_path`

## Requirements
- R1: After reset the request is low, both channel outputs are 0, the rate output is 0, the control word reads 0, the frame counter reads 0, and the status word reads free=64 with the empty flag set.
- R2: A control write (address 0x04) with bit 0 set empties the queue in that cycle. Bit 0 always reads back as 0.
- R3: A write to address 0x0c appends the word to the queue. When 64 words are already queued, the write is dropped. The status word (address 0x08) gives the free slot count in bits 23:8 and an empty flag in bit 0.
- R4: While control bit 4 is 0, the request output is low on the next cycle, whatever the fill level.
- R5: With bit 4 set, the request is registered from the fill level one cycle earlier. It clears when free < (2 << clr), where clr is control bits 22:21 (codes 0..3 give 2, 4, 8, 16). Otherwise it sets when free > the level in bits 13:8. Otherwise it holds its value.
- R6: A strobe that finds too few words for a frame is an underrun and removes nothing from the queue. With control bit 26 = 0 both outputs become 0. With bit 26 = 1 both outputs keep their previous values.
- R7: Control bit 5 = 0 takes the sample from word bits 15:0. Bit 5 = 1 takes a 24-bit sample from word bits 31:8.
- R8: For 16-bit samples, control bit 24 = 0 widens the sample by appending 8 zero bits. Bit 24 = 1 widens it by appending the sample's own top 8 bits.
- R9: With control bit 6 = 0, a frame takes two words, the oldest to the left output. With bit 6 = 1, a frame takes one word and drives both outputs. Outputs change on the cycle after the strobe.
- R10: Control bits 31:29 appear on the rate output one cycle after they are written.
- R11: The frame counter (address 0x30) adds 1 for every strobe, underruns included. Any write to 0x30 clears it, and the write wins over a strobe in the same cycle.
- R12: A data-port write and a strobe in the same cycle both take effect. The strobe sees the queue as it was before the write. A strobe in the same cycle as a flush is an underrun.
- R13: The control word reads back only its defined fields (bits 31:29, 26, 24, 22:21, 13:8, 6, 5, 4). All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| frame_tick | input | 1 | Sample-rate strobe, one frame per pulse |
| dma_req | output | 1 | Transfer request to the DMA engine |
| left_smp | output | 24 | Left channel sample |
| right_smp | output | 24 | Right channel sample |
| rate_sel | output | 3 | Stored rate code for the clock generator |

## Verification
The riskiest overlap is a data-port write landing in the same cycle as a frame strobe. The queue then gains and loses words together, and the request logic sees the combined fill level. The bench provokes this at the empty boundary, where the strobe must underrun while the new word is still accepted. It also provokes it at the full boundary, where the write is dropped while a frame still drains. A flush coinciding with a strobe is also driven. A behavioural queue model decides the outputs, request and read data for every cycle, and these are compared against the design.

// File: rtl/atx_pkg.sv
package atx_pkg;
  localparam int WORD_W = 32;
  localparam int SMP_W  = 24;
  localparam int HALF_W = 16;

  localparam int REG_CTRL = 'h04;
  localparam int REG_STAT = 'h08;
  localparam int REG_DATA = 'h0c;
  localparam int REG_CNT  = 'h30;

  localparam int B_FLUSH = 0;
  localparam int B_REQEN = 4;
  localparam int B_WIDE  = 5;
  localparam int B_MONO  = 6;
  localparam int B_TRIG  = 8;
  localparam int B_CLR   = 21;
  localparam int B_PAD   = 24;
  localparam int B_HOLD  = 26;
  localparam int B_RATE  = 29;

  localparam logic [WORD_W-1:0] CTRL_MASK = 32'hE560_3F70;

  function automatic logic [SMP_W-1:0] widen(input logic [WORD_W-1:0] w,
                                             input logic wide, input logic rep);
    logic [HALF_W-1:0] s;
    s = w[HALF_W-1:0];
    if (wide) return w[WORD_W-1:WORD_W-SMP_W];
    else if (rep) return {s, s[HALF_W-1:HALF_W-(SMP_W-HALF_W)]};
    else return {s, {(SMP_W-HALF_W){1'b0}}};
  endfunction
endpackage

// File: rtl/atx_fifo.sv
module atx_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic [1:0]    pop_n,
  output logic [W-1:0]  head0,
  output logic [W-1:0]  head1,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      rd_d  = wr_q;
      cnt_d = '0;
    end else begin
      if (push) wr_d = wr_q + AW'(1);
      rd_d  = rd_q + AW'(pop_n);
      cnt_d = cnt_q + CW'(push) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

  assign head0 = mem[rd_q];
  assign head1 = mem[rd_q + AW'(1)];
  assign count = cnt_q;
endmodule

// File: rtl/atx_frame.sv
module atx_frame
  import atx_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              flush,
  input  logic              mono,
  input  logic              wide,
  input  logic              rep,
  input  logic              hold_last,
  input  logic [CW-1:0]     count,
  input  logic [WORD_W-1:0] head0,
  input  logic [WORD_W-1:0] head1,
  output logic [1:0]        pop_n,
  output logic [SMP_W-1:0]  left,
  output logic [SMP_W-1:0]  right
);
  logic             avail;
  logic             upd;
  logic [SMP_W-1:0] l_q, l_d, r_q, r_d;

  // R9 / R12: a frame needs one word (mono) or two (stereo); flush forces underrun
  assign avail = !flush && (mono ? (count >= CW'(1)) : (count >= CW'(2)));
  assign pop_n = (tick && avail) ? (mono ? 2'd1 : 2'd2) : 2'd0;
  // R6: underrun with hold keeps the previous pair
  assign upd   = tick && (avail || !hold_last);

  always_comb begin
    l_d = l_q;
    r_d = r_q;
    if (avail) begin
      l_d = widen(head0, wide, rep);
      r_d = mono ? widen(head0, wide, rep) : widen(head1, wide, rep);
    end else begin
      l_d = '0;
      r_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q <= '0;
      r_q <= '0;
    end else if (upd) begin
      l_q <= l_d;
      r_q <= r_d;
    end
  end

  assign left  = l_q;
  assign right = r_q;
endmodule

// File: rtl/atx_dreq.sv
module atx_dreq #(
  parameter int CW     = 7,
  parameter int TRIG_W = 6,
  parameter int CLR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [TRIG_W-1:0] trig,
  input  logic [CLR_W-1:0]  clr,
  input  logic [CW-1:0]     free,
  output logic              req
);
  logic          req_q, req_d;
  logic [CW-1:0] drop_thr;

  // R5: clear codes 0..3 map to 2, 4, 8, 16 free slots
  assign drop_thr = CW'(2) << clr;

  always_comb begin
    if (!en)                   req_d = 1'b0;
    else if (free < drop_thr)  req_d = 1'b0;
    else if (free > CW'(trig)) req_d = 1'b1;
    else                       req_d = req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req = req_q;
endmodule

// File: rtl/atx_tx_path.sv
module atx_tx_path
  import atx_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              frame_tick,
  output logic              dma_req,
  output logic [SMP_W-1:0]  left_smp,
  output logic [SMP_W-1:0]  right_smp,
  output logic [2:0]        rate_sel
);
  logic [WORD_W-1:0] ctrl_q, ctrl_d, cnt_q, cnt_d;
  logic [WORD_W-1:0] head0, head1;
  logic [CW-1:0]     fifo_count, free;
  logic [1:0]        pop_n;
  logic              wr_ctrl, wr_data, wr_cnt, flush, push;

  assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(REG_CTRL));
  assign wr_data = bus_we && (bus_addr == ADDR_W'(REG_DATA));
  assign wr_cnt  = bus_we && (bus_addr == ADDR_W'(REG_CNT));
  assign flush   = wr_ctrl && bus_wdata[B_FLUSH];
  // R3: writes into a full queue are dropped
  assign push    = wr_data && (fifo_count < CW'(DEPTH));
  assign free    = CW'(DEPTH) - fifo_count;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = bus_wdata & CTRL_MASK;
  end

  // R11: clear wins over increment
  always_comb begin
    cnt_d = cnt_q;
    if (wr_cnt)          cnt_d = '0;
    else if (frame_tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
    end
  end

  atx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .wdata(bus_wdata),
    .pop_n(pop_n), .head0(head0), .head1(head1), .count(fifo_count)
  );

  atx_frame #(.CW(CW)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick), .flush(flush),
    .mono(ctrl_q[B_MONO]), .wide(ctrl_q[B_WIDE]), .rep(ctrl_q[B_PAD]),
    .hold_last(ctrl_q[B_HOLD]), .count(fifo_count), .head0(head0), .head1(head1),
    .pop_n(pop_n), .left(left_smp), .right(right_smp)
  );

  atx_dreq #(.CW(CW), .TRIG_W(6), .CLR_W(2)) u_dreq (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q[B_REQEN]),
    .trig(ctrl_q[B_TRIG +: 6]), .clr(ctrl_q[B_CLR +: 2]), .free(free), .req(dma_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(REG_CTRL))      bus_rdata = ctrl_q;
    else if (bus_addr == ADDR_W'(REG_STAT)) bus_rdata = {8'h00, 16'(free), 7'h00, (fifo_count == '0)};
    else if (bus_addr == ADDR_W'(REG_CNT))  bus_rdata = cnt_q;
  end

  assign rate_sel = ctrl_q[B_RATE +: 3];
endmodule

// File: rtl/atx_chk.sv
module atx_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        frame_tick,
  input logic [31:0] ctrl,
  input logic [31:0] cnt,
  input logic [CW-1:0] count,
  input logic        req,
  input logic [23:0] left,
  input logic [23:0] right
);
  logic flush_w, cnt_w;
  assign flush_w = bus_we && bus_addr == 8'h04 && bus_wdata[0];
  assign cnt_w   = bus_we && bus_addr == 8'h30;

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r2_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_w |=> count == '0);
  a_r4_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[4] |=> !req);
  a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[4] && ctrl[22:21] == 2'd3 && (CW'(DEPTH) - count) < CW'(16)) |=> !req);
  a_r6_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && count == '0 && !ctrl[26]) |=> (left == '0 && right == '0));
  a_r6_hold_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && count == '0 && ctrl[26]) |=> ($stable(left) && $stable(right)));
  a_r9_mono_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && ctrl[6] && count != '0 && !flush_w) |=> left == right);
  a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !cnt_w) |=> cnt == $past(cnt) + 32'd1);
endmodule

bind atx_tx_path atx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .frame_tick(frame_tick), .ctrl(ctrl_q), .cnt(cnt_q),
  .count(fifo_count), .req(dma_req), .left(left_smp), .right(right_smp)
);

// File: tb/sim_atx_tx_path.sv
module sim_atx_tx_path;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h08;
  logic [31:0] bus_wdata = '0;
  logic        frame_tick = 1'b0;
  logic [31:0] bus_rdata;
  logic        dma_req;
  logic [23:0] left_smp, right_smp;
  logic [2:0]  rate_sel;

  always #2 clk = ~clk;

  atx_tx_path u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_tick(frame_tick),
    .dma_req(dma_req), .left_smp(left_smp), .right_smp(right_smp), .rate_sel(rate_sel)
  );

  int total = 0;
  int bad = 0;
  string tag = "R1";
  logic [7:0] rd_sel = 8'h08;

  // behavioural reference
  logic [31:0] q[$];
  logic [31:0] m_ctrl, m_cnt;
  logic [23:0] m_l, m_r;
  logic        m_req;

  function automatic logic [23:0] bw(input logic [31:0] w, input logic wd, input logic rp);
    if (wd) return w[31:8];
    if (rp) return {w[15:0], w[15:8]};
    return {w[15:0], 8'h00};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    int fr;
    fr = 64 - q.size();
    case (a)
      8'h04: return m_ctrl;
      8'h08: return {8'h00, 16'(fr), 7'h00, q.size() == 0};
      8'h30: return m_cnt;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    int oldn, fr, thr;
    logic fl, nreq;
    logic [31:0] h0, h1;
    if (!rst_n) begin
      q.delete();
      m_ctrl = '0; m_cnt = '0; m_l = '0; m_r = '0; m_req = 1'b0;
    end else begin
      oldn = q.size();
      fr   = 64 - oldn;
      thr  = 2 << m_ctrl[22:21];
      if (!m_ctrl[4])              nreq = 1'b0;
      else if (fr < thr)           nreq = 1'b0;
      else if (fr > m_ctrl[13:8])  nreq = 1'b1;
      else                         nreq = m_req;
      fl = bus_we && bus_addr == 8'h04 && bus_wdata[0];
      if (frame_tick) begin
        if (!fl && oldn >= (m_ctrl[6] ? 1 : 2)) begin
          h0 = q.pop_front();
          m_l = bw(h0, m_ctrl[5], m_ctrl[24]);
          if (m_ctrl[6]) m_r = m_l;
          else begin
            h1 = q.pop_front();
            m_r = bw(h1, m_ctrl[5], m_ctrl[24]);
          end
        end else if (!m_ctrl[26]) begin
          m_l = '0; m_r = '0;
        end
      end
      if (bus_we && bus_addr == 8'h30) m_cnt = '0;
      else if (frame_tick)             m_cnt = m_cnt + 1;
      if (bus_we && bus_addr == 8'h0c && oldn < 64) q.push_back(bus_wdata);
      if (fl) q.delete();
      if (bus_we && bus_addr == 8'h04) m_ctrl = bus_wdata & 32'hE560_3F70;
      m_req = nreq;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d, input logic tk);
    @(negedge clk);
    chk("left", 32'(left_smp), 32'(m_l));
    chk("right", 32'(right_smp), 32'(m_r));
    chk("req", 32'(dma_req), 32'(m_req));
    chk("rate", 32'(rate_sel), 32'(m_ctrl[31:29]));
    chk("rdata", bus_rdata, exp_rd(bus_addr));
    bus_we = we; bus_addr = we ? a : rd_sel; bus_wdata = d; frame_tick = tk;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, rd_sel, '0, 1'b0);
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, a, d, 1'b0);
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, rd_sel, '0, 1'b1);
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state through status, control and counter
    tag = "R1";
    rd_sel = 8'h08; idle(2);
    rd_sel = 8'h04; idle(2);
    rd_sel = 8'h30; idle(2);
    // R10 / R13: rate code and masked readback
    tag = "R13"; rd_sel = 8'h04;
    wr(8'h04, 32'hBFFF_FFFE); idle(2);
    tag = "R10";
    wr(8'h04, 32'hA000_0000); idle(2);
    // R7 / R8 / R9: stereo, 16-bit, zero padding
    tag = "R9"; rd_sel = 8'h08;
    wr(8'h0c, 32'h0000_1234); wr(8'h0c, 32'h0000_ABCD);
    wr(8'h0c, 32'h0000_8001); wr(8'h0c, 32'h0000_7FFE);
    ticks(1); idle(1); ticks(1); idle(2);
    // R8: repeat padding
    tag = "R8";
    wr(8'h04, 32'h0100_0000);
    wr(8'h0c, 32'h0000_C35A); wr(8'h0c, 32'h0000_0F0F);
    ticks(1); idle(2);
    // R7: 24-bit samples from bits 31:8
    tag = "R7";
    wr(8'h04, 32'h0000_0020);
    wr(8'h0c, 32'h1234_56FF); wr(8'h0c, 32'hFEDC_BA11);
    ticks(1); idle(2);
    // R9: mono duplication
    tag = "R9";
    wr(8'h04, 32'h0000_0040);
    wr(8'h0c, 32'h0000_5555); wr(8'h0c, 32'h0000_AAAA);
    ticks(1); idle(1); ticks(1); idle(2);
    // R6: underrun with hold, then zero; stereo with a single word
    tag = "R6";
    wr(8'h0c, 32'h0000_4321); ticks(1); idle(1);
    wr(8'h04, 32'h0400_0000); ticks(2); idle(1);
    wr(8'h0c, 32'h0000_1111); ticks(1); idle(1);
    wr(8'h04, 32'h0000_0000); ticks(2); idle(1);
    wr(8'h04, 32'h0000_0001); idle(1);
    // R3: fill past capacity; extra writes dropped
    tag = "R3";
    for (int i = 0; i < 66; i++) wr(8'h0c, 32'(i * 257));
    idle(2); ticks(1); idle(2);
    // R2: flush empties and reads back 0
    tag = "R2";
    wr(8'h04, 32'h0000_0001); idle(2);
    // R4 / R5: hysteresis, trig 40, clear code 3
    tag = "R4";
    wr(8'h04, 32'h0060_2800); idle(2);
    for (int i = 0; i < 20; i++) wr(8'h0c, 32'(i));
    tag = "R5";
    wr(8'h04, 32'h0060_2810); idle(2);
    for (int i = 0; i < 40; i++) wr(8'h0c, 32'(i + 100));
    idle(2);
    for (int i = 0; i < 30; i++) ticks(1);
    idle(2);
    for (int c = 0; c < 3; c++) begin
      wr(8'h04, 32'h0000_0001);
      wr(8'h04, 32'h0000_0010 | (32'(c) << 21));
      for (int i = 0; i < 64; i++) wr(8'h0c, 32'(i));
      idle(2);
      ticks(3); idle(2);
    end
    tag = "R4";
    wr(8'h04, 32'h0000_0001); wr(8'h04, 32'h0000_0000); idle(3);
    // R12: write plus strobe together at empty and at full; flush plus strobe
    tag = "R12";
    step(1'b1, 8'h0c, 32'h0000_2222, 1'b1); idle(1);
    step(1'b1, 8'h0c, 32'h0000_3333, 1'b1); idle(2);
    for (int i = 0; i < 64; i++) wr(8'h0c, 32'(i + 7));
    step(1'b1, 8'h0c, 32'h0000_9999, 1'b1); idle(1);
    step(1'b1, 8'h0c, 32'h0000_8888, 1'b1); idle(2);
    step(1'b1, 8'h04, 32'h0000_0001, 1'b1); idle(2);
    // R11: counter clear, and clear winning over a strobe
    tag = "R11"; rd_sel = 8'h30;
    ticks(3); idle(1);
    wr(8'h30, 32'hFFFF_FFFF); idle(1);
    ticks(2);
    step(1'b1, 8'h30, 32'h0, 1'b1); idle(2);
    ticks(1); idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule